// File: doc/BRIEF.md
# Software-Armed Watchdog Timer

This block is a watchdog kept in one 8-bit control word. Software arms it by setting the arm bit. From then on, the six-bit countdown field drops by one on each qualified tick. When the field runs past zero, the block raises a system reset pulse. Software keeps the system alive by rewriting the countdown field before it runs out. It can also force a reset on purpose by writing a zero to the kill bit while the watchdog is armed.

The tick input comes from a clock divider outside this block. While the stop input is high, ticks are ignored, so the countdown holds during stop mode and picks up again once stop is released. After arming, any reset request is held back until a fixed hold-off window has passed. At the end of the reset pulse the control word returns to its power-up value.

Top module: `swdt_top`

## Requirements
- R1: After reset the control word reads 0xFE and `sys_rst_o` is low. The bit layout is: bit 0 is the arm bit (1 = armed), bit 1 is the kill bit (writing 0 while armed forces a reset), and bits 7:2 are the countdown field.
- R2: While disarmed, ticks leave the control word unchanged. A write stores all eight bits as written, and a kill bit of 0 causes no reset.
- R3: While armed, each cycle with `tick_i` high, `stop_i` low and no write lowers the countdown field by one. The result is visible after that clock edge.
- R4: Once the arm bit is set, writing 0 to it has no effect. Only the end of a reset pulse or the system reset clears it.
- R5: While `stop_i` is high, ticks do not change the countdown field. Counting resumes when `stop_i` goes low.
- R6: While armed, a tick with the countdown field at 0 raises `sys_rst_o` after that edge, provided the hold-off window has elapsed.
- R7: A write that leaves the watchdog armed and has bit 1 at 0 raises `sys_rst_o` after the write edge, provided the hold-off window has elapsed.
- R8: `sys_rst_o` stays high for exactly PULSE_CYCLES (default 4) cycles. After it falls, the control word reads 0xFE.
- R9: No reset is raised within GUARD_CYCLES (default 28) edges after the arming write. A request made inside that window is held and issued on edge GUARD_CYCLES+1 after the arming edge.
- R10: A write while armed replaces the countdown field. A write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 8 | Write data for the control word |
| rd_data_o | output | 8 | Current control word |
| tick_i | input | 1 | One-cycle countdown tick from the external divider |
| stop_i | input | 1 | High while the system is in stop mode |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
The assertions assume that `tick_i` and `wr_en_i` are single-cycle, synchronous strobes. They also assume that PULSE_CYCLES and GUARD_CYCLES are at least 1. The bench changes every input only on falling edges and holds each strobe for exactly one cycle. It waits out the full hold-off window before testing a timeout or a kill write, and only tests the deferred path on purpose, right after arming.

// File: rtl/swdt_pkg.sv
package swdt_pkg;
  // bit positions inside the control word; software decodes these
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned KILL_BIT = 1;
  localparam int unsigned CNT_LSB  = 2;
endpackage

// File: rtl/swdt_ctrl.sv
module swdt_ctrl
  import swdt_pkg::*;
#(
  parameter  int unsigned CNT_W = 6,
  localparam int unsigned REG_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             tick_i,
  input  logic             stop_i,
  input  logic             freeze_i,
  input  logic             restore_i,
  output logic [REG_W-1:0] word_o,
  output logic             activate_o,
  output logic             req_o
);
  localparam logic [REG_W-1:0] RST_VAL = {{(REG_W-1){1'b1}}, 1'b0};

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  logic [REG_W-1:0] word_q, word_d;
  logic             en_q, en_after_wr, count_ev, kill_req, expire_req;
  logic [CNT_W-1:0] cnt_q;

  assign en_q        = word_q[EN_BIT];
  assign cnt_q       = word_q[REG_W-1:CNT_LSB];
  assign en_after_wr = en_q | wr_data_i[EN_BIT];
  assign count_ev    = en_q & tick_i & ~stop_i & ~wr_en_i & ~freeze_i;
  assign activate_o  = ~freeze_i & wr_en_i & ~en_q & wr_data_i[EN_BIT];
  assign kill_req    = ~freeze_i & wr_en_i & en_after_wr & ~wr_data_i[KILL_BIT];
  assign expire_req  = count_ev & (cnt_q == '0);
  assign req_o       = kill_req | expire_req;
  assign word_o      = word_q;

  always_comb begin
    word_d = word_q;
    if (restore_i) begin
      word_d = RST_VAL;
    end else if (!freeze_i) begin
      if (wr_en_i) begin
        word_d = {wr_data_i[REG_W-1:CNT_LSB], wr_data_i[KILL_BIT], en_after_wr};
      end else if (count_ev) begin
        word_d[REG_W-1:CNT_LSB] = cnt_dec(cnt_q);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= RST_VAL;
    else         word_q <= word_d;
  end

  // R2
  disarmed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr_en_i && !restore_i) |=> $stable(word_q));
  // R3
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_ev && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R4
  arm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !restore_i) |=> en_q);
  // R5
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr_en_i && !restore_i) |=> $stable(word_q));
endmodule

// File: rtl/swdt_holdoff.sv
module swdt_holdoff #(
  parameter  int unsigned GUARD_CYCLES = 28,
  localparam int unsigned GW = $clog2(GUARD_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic activate_i,
  input  logic req_i,
  input  logic busy_i,
  output logic fire_o
);
  logic [GW-1:0] guard_q;
  logic          pend_q, guard_open;

  assign guard_open = (guard_q == '0) & ~activate_i;
  assign fire_o     = ~busy_i & guard_open & (req_i | pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guard_q <= '0;
      pend_q  <= 1'b0;
    end else if (activate_i) begin
      guard_q <= GW'(GUARD_CYCLES);
      pend_q  <= req_i;
    end else begin
      if (guard_q != '0) guard_q <= guard_q - GW'(1);
      if (fire_o)        pend_q  <= 1'b0;
      else if (req_i)    pend_q  <= 1'b1;
    end
  end

  // checker: cycles since the last arming edge, saturating
  logic [GW-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          since_q <= GW'(GUARD_CYCLES);
    else if (activate_i)                  since_q <= '0;
    else if (since_q < GW'(GUARD_CYCLES)) since_q <= since_q + GW'(1);
  end

  // R9
  holdoff_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (since_q >= GW'(GUARD_CYCLES)));
  // R9
  deferred_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && since_q >= GW'(GUARD_CYCLES) && !busy_i && !activate_i) |-> fire_o);
endmodule

// File: rtl/swdt_pulse.sv
module swdt_pulse #(
  parameter  int unsigned PULSE_CYCLES = 4,
  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic busy_o,
  output logic done_o
);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (fire_i)        left_q <= PW'(PULSE_CYCLES);
    else if (left_q != '0)  left_q <= left_q - PW'(1);
  end

  assign busy_o = (left_q != '0);
  assign done_o = (left_q == PW'(1));

  // checker: length of the current high phase
  logic [PW-1:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_len_q <= '0;
    else if (busy_o)  hi_len_q <= hi_len_q + PW'(1);
    else              hi_len_q <= '0;
  end

  // R8
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (hi_len_q < PW'(PULSE_CYCLES)));
  // R8
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/swdt_top.sv
module swdt_top #(
  parameter  int unsigned CNT_W        = 6,
  parameter  int unsigned GUARD_CYCLES = 28,
  parameter  int unsigned PULSE_CYCLES = 4,
  localparam int unsigned REG_W        = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             tick_i,
  input  logic             stop_i,
  output logic             sys_rst_o
);
  localparam logic [REG_W-1:0] RST_VAL = {{(REG_W-1){1'b1}}, 1'b0};

  logic activate, req, fire, busy, done;

  swdt_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .tick_i(tick_i), .stop_i(stop_i), .freeze_i(busy), .restore_i(done),
    .word_o(rd_data_o), .activate_o(activate), .req_o(req)
  );

  swdt_holdoff #(.GUARD_CYCLES(GUARD_CYCLES)) holdoff_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .activate_i(activate), .req_i(req),
    .busy_i(busy), .fire_o(fire)
  );

  swdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) pulse_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .busy_o(busy), .done_o(done)
  );

  assign sys_rst_o = busy;

  // R6
  fire_to_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> sys_rst_o);
  // R8
  restore_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (rd_data_o == RST_VAL));
endmodule

// File: tb/swdt_top_tb_top.sv
module swdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int GUARD      = 28;
  localparam int PULSE      = 4;
  localparam int REG_W      = CNT_W + 2;
  localparam logic [REG_W-1:0] RST_VAL = 8'hFE;

  logic             clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick = 1'b0, stop = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_data;
  logic             sys_rst;

  swdt_top #(.CNT_W(CNT_W), .GUARD_CYCLES(GUARD), .PULSE_CYCLES(PULSE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .tick_i(tick), .stop_i(stop), .sys_rst_o(sys_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [REG_W-1:0] rd;
    bit               chk_rd;
    logic             rst;
    string            tag;
  } exp_t;
  exp_t exp_q[$];
  event sample_ev;

  // countdown in bits 7:2, kill in bit 1, arm in bit 0
  function automatic logic [REG_W-1:0] pack(int cnt, bit kill, bit en);
    logic [CNT_W-1:0] c;
    c = cnt[CNT_W-1:0];
    return {c, kill, en};
  endfunction

  task automatic expect_out(logic [REG_W-1:0] rd, bit chk_rd, logic rst, string tag);
    exp_t e;
    e.rd = rd; e.chk_rd = chk_rd; e.rst = rst; e.tag = tag;
    exp_q.push_back(e);
    -> sample_ev;
  endtask

  task automatic check_int(int act, int exp, string tag);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial forever begin
    @(sample_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      vectors++;
      if (sys_rst !== e.rst || (e.chk_rd && rd_data !== e.rd)) begin
        miscompares++;
        $display("FAIL %s: rd=%h rst=%b expected rd=%h rst=%b",
                 e.tag, rd_data, sys_rst, e.rd, e.rst);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(logic [REG_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic write_with_tick(logic [REG_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_out(RST_VAL, 1, 1'b0, "R1 reset value");

    // R2: disarmed
    repeat (4) tick_once();
    expect_out(RST_VAL, 1, 1'b0, "R2 ticks while disarmed");
    write_word(pack(2, 1, 0));
    repeat (3) tick_once();
    expect_out(pack(2, 1, 0), 1, 1'b0, "R2 stored write no count");
    write_word(pack(2, 0, 0));
    idle(2);
    expect_out(pack(2, 0, 0), 1, 1'b0, "R2 kill ignored while disarmed");

    // R3: arm and count
    write_word(pack(10, 1, 1));
    expect_out(pack(10, 1, 1), 1, 1'b0, "R3 armed word");
    repeat (3) tick_once();
    expect_out(pack(7, 1, 1), 1, 1'b0, "R3 three decrements");

    // R5: stop freezes
    @(negedge clk); stop = 1'b1;
    repeat (3) tick_once();
    expect_out(pack(7, 1, 1), 1, 1'b0, "R5 frozen in stop");
    @(negedge clk); stop = 1'b0;
    tick_once();
    expect_out(pack(6, 1, 1), 1, 1'b0, "R5 resumed");

    // R4 / R10
    write_word(pack(20, 1, 0));
    expect_out(pack(20, 1, 1), 1, 1'b0, "R4 arm bit sticky, R10 refresh");
    write_with_tick(pack(33, 1, 1));
    expect_out(pack(33, 1, 1), 1, 1'b0, "R10 write beats tick");

    // R6 timeout, R8 pulse
    idle(40);
    write_word(pack(1, 1, 1));
    tick_once();
    expect_out(pack(0, 1, 1), 1, 1'b0, "R6 reached zero no reset yet");
    tick_once();
    expect_out(RST_VAL, 0, 1'b1, "R6 timeout reset");
    begin
      int hi;
      hi = 1;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (sys_rst) hi++;
        else break;
      end
      check_int(hi, PULSE, "R8 pulse length");
    end
    expect_out(RST_VAL, 1, 1'b0, "R8 restored word");

    // R9 hold-off window with a kill requested at arming
    write_word(pack(63, 0, 1));
    expect_out(pack(63, 0, 1), 1, 1'b0, "R9 arming edge");
    for (int k = 1; k <= GUARD; k++) begin
      @(negedge clk);
      expect_out(pack(63, 0, 1), 1, 1'b0, "R9 inside hold-off");
    end
    @(negedge clk);
    expect_out(RST_VAL, 0, 1'b1, "R9 deferred reset issued");
    idle(PULSE);
    expect_out(RST_VAL, 1, 1'b0, "R9 R8 restored after deferred");

    // R7 kill write
    write_word(pack(5, 1, 1));
    idle(40);
    expect_out(pack(5, 1, 1), 1, 1'b0, "R7 armed idle");
    write_word(pack(5, 0, 1));
    expect_out(RST_VAL, 0, 1'b1, "R7 kill reset");
    idle(PULSE);
    expect_out(RST_VAL, 1, 1'b0, "R7 R8 restored after kill");

    #1;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule